// File: doc/BRIEF.md
# Load/Store Byte Lane Aligner

This block sits between an execute stage and a 32-bit little-endian data memory port. It receives one access per cycle: a base register, a signed 12-bit displacement, a 3-bit width/sign code and, for stores, the source register. It forms the effective byte address and issues a word-addressed memory transaction.

For a store, the block produces byte enables and places the data in the correct lanes. For a load, it records which lanes were addressed, selects them from the word that memory returns one cycle later, and sign- or zero-extends them to 32 bits.

Accesses that are not naturally aligned are not split into several transactions. They raise a misalignment flag and go nowhere. Width codes that have no meaning raise an illegal-operation flag and also go nowhere. The memory is assumed to accept every request, and it returns read data exactly one cycle after a read request.

Top module: `lsu_lane_aligner`

## Requirements
- R1: The effective address is `base_i` plus the 12-bit `disp_i` sign-extended. `mem_addr_o` carries that address with bits 1:0 forced to zero, and those two bits select the lane.
- R2: Byte enables are 0001 shifted left by addr[1:0] for a byte, 0011 shifted left by 2*addr[1] for a halfword, and 1111 for a word. `mem_be_o` is 0000 when no transaction is issued.
- R3: Store data is taken from the low-order bits of `wr_data_i`: bits 7:0 for a byte, 15:0 for a halfword, 31:0 for a word. It is moved to the enabled lanes, where lane k is `mem_wdata_o[8k+7:8k]` and the lowest address maps to lane 0. Lanes that are not enabled are zero.
- R4: A load with width code 000 (byte) or 001 (halfword) returns the selected byte or halfword with its top bit copied into all upper bits of `load_data_o`.
- R5: A load with width code 100 (byte) or 101 (halfword) returns the selected byte or halfword with zeros in all upper bits.
- R6: A load with width code 010 returns the whole returned word unchanged.
- R7: `load_valid_o` is high in exactly the cycle after a read transaction is issued. The lane used is the one captured at request time.
- R8: A halfword whose address has bit 0 set, or a word whose address bits 1:0 are not 00, asserts `misaligned_o` and issues no transaction.
- R9: Store codes 011 to 111 and load codes 011, 110 and 111 assert `illegal_o`, issue no transaction and keep `misaligned_o` low.
- R10: While `req_valid_i` is low, or during reset, `mem_req_o`, `illegal_o` and `misaligned_o` stay low, and no load response follows.
- R11: `mem_we_o` is high for an issued store and low for an issued load. A store is never followed by `load_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_code_i | input | 3 | Width/sign code |
| base_i | input | 32 | Base register value |
| disp_i | input | 12 | Signed displacement |
| wr_data_i | input | 32 | Store source register value |
| mem_req_o | output | 1 | Memory transaction issued |
| mem_we_o | output | 1 | Transaction is a write |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_be_o | output | 4 | Byte lane enables |
| mem_wdata_o | output | 32 | Lane-steered write data |
| mem_rdata_i | input | 32 | Read word, valid one cycle after a read |
| misaligned_o | output | 1 | Request not naturally aligned |
| illegal_o | output | 1 | Width code not defined for the operation |
| load_valid_o | output | 1 | `load_data_o` is valid |
| load_data_o | output | 32 | Extracted and extended load result |

## Verification
The request path is combinational, so any error in decode or lane steering shows up in the same cycle as the request. It appears at `mem_be_o`, `mem_wdata_o`, the two fault flags or `mem_req_o`.

The only state is the captured lane, size and sign of a pending read. If that state is wrong, it appears one cycle later, either as a result taken from the wrong lane or extended the wrong way, or as `load_valid_o` after a store, a fault or an idle cycle. The sweep covers every code, both directions and all four address offsets, including displacements that carry into or borrow from the upper address bits. Each request is followed by an idle cycle, so any stray response is seen on its own.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned LANES      = WORD_W / 8;
  localparam int unsigned LANE_IDX_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } acc_size_e;

  typedef struct packed {
    acc_size_e size;
    logic      is_signed;
    logic      legal;
  } acc_kind_t;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic       is_store_i,
  input  logic [2:0] code_i,
  output acc_kind_t  kind_o
);
  always_comb begin
    kind_o.size      = acc_size_e'(code_i[1:0]);
    kind_o.is_signed = ~code_i[2];
    if (is_store_i) kind_o.legal = (code_i == 3'b000) || (code_i == 3'b001) || (code_i == 3'b010);
    else            kind_o.legal = (code_i[1:0] != 2'b11) && !(code_i[2] && code_i[1]);
  end
endmodule

// File: rtl/lsu_store_align.sv
module lsu_store_align
  import lsu_pkg::*;
#(
  parameter int unsigned N_LANES = LANES,
  localparam int unsigned IDX_W  = $clog2(N_LANES),
  localparam int unsigned DW     = 8 * N_LANES
) (
  input  acc_size_e          size_i,
  input  logic [IDX_W-1:0]   off_i,
  input  logic [DW-1:0]      src_i,
  output logic [N_LANES-1:0] be_o,
  output logic [DW-1:0]      data_o
);
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam logic [IDX_W-1:0] LI = IDX_W'(g);
    logic       lane_en;
    logic [7:0] lane_byte;
    always_comb begin
      case (size_i)
        SZ_BYTE: begin
          lane_en   = (off_i == LI);
          lane_byte = src_i[7:0];
        end
        SZ_HALF: begin
          lane_en   = (off_i[IDX_W-1:1] == LI[IDX_W-1:1]);
          lane_byte = src_i[8*(g%2) +: 8];
        end
        default: begin
          lane_en   = 1'b1;
          lane_byte = src_i[8*g +: 8];
        end
      endcase
    end
    assign be_o[g]          = lane_en;
    assign data_o[8*g +: 8] = lane_en ? lane_byte : 8'h00;
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int unsigned N_LANES = LANES,
  localparam int unsigned IDX_W  = $clog2(N_LANES),
  localparam int unsigned DW     = 8 * N_LANES
) (
  input  logic [DW-1:0]    word_i,
  input  logic [IDX_W-1:0] off_i,
  input  acc_size_e        size_i,
  input  logic             is_signed_i,
  output logic [DW-1:0]    result_o
);
  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_comb begin
    sel_b = word_i[8*off_i +: 8];
    sel_h = word_i[16*off_i[IDX_W-1:1] +: 16];
    case (size_i)
      SZ_BYTE: result_o = {{(DW-8){is_signed_i & sel_b[7]}}, sel_b};
      SZ_HALF: result_o = {{(DW-16){is_signed_i & sel_h[15]}}, sel_h};
      default: result_o = word_i;
    endcase
  end
endmodule

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 12,
  localparam int unsigned DW    = WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [2:0]        req_code_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              misaligned_o,
  output logic              illegal_o,
  output logic              load_valid_o,
  output logic [DW-1:0]     load_data_o
);
  acc_kind_t              kind;
  logic [ADDR_W-1:0]      eff_addr;
  logic [LANE_IDX_W-1:0]  lane_off;
  logic                   align_bad;
  logic [LANES-1:0]       be_raw;
  logic [DW-1:0]          wdata_raw;

  logic                   pend_q;
  logic [LANE_IDX_W-1:0]  off_q;
  acc_size_e              size_q;
  logic                   sign_q;

  lsu_decode i_decode (
    .is_store_i (req_store_i),
    .code_i     (req_code_i),
    .kind_o     (kind)
  );

  assign eff_addr = base_i + {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign lane_off = eff_addr[LANE_IDX_W-1:0];

  always_comb begin
    case (kind.size)
      SZ_HALF: align_bad = lane_off[0];
      SZ_WORD: align_bad = |lane_off;
      default: align_bad = 1'b0;
    endcase
  end

  assign illegal_o    = req_valid_i & ~kind.legal;
  assign misaligned_o = req_valid_i & kind.legal & align_bad;
  assign mem_req_o    = req_valid_i & kind.legal & ~align_bad;
  assign mem_we_o     = mem_req_o & req_store_i;
  assign mem_addr_o   = {eff_addr[ADDR_W-1:LANE_IDX_W], {LANE_IDX_W{1'b0}}};

  lsu_store_align #(.N_LANES(LANES)) i_store_align (
    .size_i (kind.size),
    .off_i  (lane_off),
    .src_i  (wr_data_i),
    .be_o   (be_raw),
    .data_o (wdata_raw)
  );

  assign mem_be_o    = mem_req_o ? be_raw : '0;
  assign mem_wdata_o = mem_we_o ? wdata_raw : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      off_q  <= '0;
      size_q <= SZ_WORD;
      sign_q <= 1'b0;
    end else begin
      pend_q <= mem_req_o & ~req_store_i;
      if (mem_req_o && !req_store_i) begin
        off_q  <= lane_off;
        size_q <= kind.size;
        sign_q <= kind.is_signed;
      end
    end
  end

  lsu_load_extract #(.N_LANES(LANES)) i_load_extract (
    .word_i      (mem_rdata_i),
    .off_i       (off_q),
    .size_i      (size_q),
    .is_signed_i (sign_q),
    .result_o    (load_data_o)
  );

  assign load_valid_o = pend_q;

  logic [DW-1:0] be_mask;
  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign be_mask[8*g +: 8] = {8{mem_be_o[g]}};
  end

  assert_addr_word_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[LANE_IDX_W-1:0] == '0));
  assert_be_shape_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_be_o inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111}));
  assert_unused_lanes_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ((mem_wdata_o & ~be_mask) == '0));
  assert_zext_byte_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_valid_o && !sign_q && size_q == SZ_BYTE) |-> (load_data_o[DW-1:8] == '0));
  assert_resp_after_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> load_valid_o);
  assert_no_stray_resp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && !mem_we_o) |=> !load_valid_o);
  assert_misalign_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misaligned_o |-> !mem_req_o);
  assert_illegal_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!mem_req_o && !misaligned_o));
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!mem_req_o && !illegal_o && !misaligned_o));
  assert_store_no_resp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !load_valid_o);
endmodule

// File: tb/test_lsu_lane_aligner.sv
module test_lsu_lane_aligner;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_valid_i, req_store_i;
  logic [2:0]  req_code_i;
  logic [31:0] base_i, wr_data_i, mem_rdata_i;
  logic [11:0] disp_i;
  logic        mem_req_o, mem_we_o, misaligned_o, illegal_o, load_valid_o;
  logic [31:0] mem_addr_o, mem_wdata_o, load_data_o;
  logic [3:0]  mem_be_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i;

  lsu_lane_aligner i_lsu_lane_aligner (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input bit st, input logic [2:0] code, input logic [31:0] base,
                       input logic [11:0] disp, input logic [31:0] src, input logic [31:0] rword);
    logic [31:0] ea, e_wd, e_ld;
    logic [3:0]  e_be;
    logic [1:0]  lo;
    bit          legal, mis, issue;
    int          sz;
    ea    = base + {{20{disp[11]}}, disp};
    lo    = ea[1:0];
    sz    = int'(code[1:0]);
    legal = st ? (code <= 3'd2) : (code inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd5});
    mis   = legal && ((sz == 1 && lo[0]) || (sz == 2 && lo != 2'd0));
    issue = legal && !mis;
    case (sz)
      0:       begin e_be = 4'b0001 << lo; e_wd = (src & 32'hFF) << (8 * lo); end
      1:       begin e_be = 4'b0011 << lo; e_wd = (src & 32'hFFFF) << (8 * lo); end
      default: begin e_be = 4'b1111;       e_wd = src; end
    endcase
    @(negedge clk_i);
    req_valid_i = 1'b1; req_store_i = st; req_code_i = code;
    base_i = base; disp_i = disp; wr_data_i = src;
    #1;
    chk(illegal_o == !legal, "R9 illegal flag", 32'(illegal_o), 32'(!legal));
    chk(misaligned_o == mis, "R8 misaligned flag", 32'(misaligned_o), 32'(mis));
    chk(mem_req_o == issue, "R8 R9 request gating", 32'(mem_req_o), 32'(issue));
    if (issue) begin
      chk(mem_addr_o == {ea[31:2], 2'b00}, "R1 address", mem_addr_o, {ea[31:2], 2'b00});
      chk(mem_be_o == e_be, "R2 byte enables", 32'(mem_be_o), 32'(e_be));
      chk(mem_we_o == st, "R11 write enable", 32'(mem_we_o), 32'(st));
      if (st) chk(mem_wdata_o == e_wd, "R3 write data", mem_wdata_o, e_wd);
    end else begin
      chk(mem_be_o == 4'b0000, "R2 no enables without request", 32'(mem_be_o), 32'h0);
    end
    @(negedge clk_i);
    req_valid_i = 1'b0;
    mem_rdata_i = rword;
    base_i = ~base;
    #1;
    chk(mem_req_o == 1'b0 && illegal_o == 1'b0 && misaligned_o == 1'b0, "R10 idle quiet",
        {29'd0, mem_req_o, illegal_o, misaligned_o}, 32'h0);
    chk(load_valid_o == (issue && !st), "R7 R11 response strobe", 32'(load_valid_o), 32'(issue && !st));
    if (issue && !st) begin
      case (sz)
        0: begin
          e_ld = (rword >> (8 * lo)) & 32'hFF;
          if (!code[2] && e_ld[7]) e_ld = e_ld | 32'hFFFF_FF00;
        end
        1: begin
          e_ld = (rword >> (8 * lo)) & 32'hFFFF;
          if (!code[2] && e_ld[15]) e_ld = e_ld | 32'hFFFF_0000;
        end
        default: e_ld = rword;
      endcase
      if (sz == 2)      chk(load_data_o == e_ld, "R6 word load", load_data_o, e_ld);
      else if (code[2]) chk(load_data_o == e_ld, "R5 zero-extended load", load_data_o, e_ld);
      else              chk(load_data_o == e_ld, "R4 sign-extended load", load_data_o, e_ld);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] pats [2];
    logic [11:0] disps [4];
    pats[0]  = 32'hC3A5_96F0;
    pats[1]  = 32'h1E6B_7A3C;
    disps[0] = 12'h000;
    disps[1] = 12'h7FF;
    disps[2] = 12'h800;
    disps[3] = 12'hFFD;
    rst_ni = 1'b0; req_valid_i = 1'b0; req_store_i = 1'b0; req_code_i = 3'd0;
    base_i = '0; disp_i = '0; wr_data_i = '0; mem_rdata_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    #1;
    chk(mem_req_o == 1'b0 && load_valid_o == 1'b0, "R10 reset state",
        {30'd0, mem_req_o, load_valid_o}, 32'h0);
    rst_ni = 1'b1;
    for (int st = 0; st < 2; st++)
      for (int c = 0; c < 8; c++)
        for (int b = 0; b < 4; b++)
          for (int d = 0; d < 4; d++)
            for (int p = 0; p < 2; p++)
              do_op(st[0], 3'(c), 32'h0000_2000 + 32'(b) + 32'(p * 32'h0100_0000),
                    disps[d], pats[p],
                    {pats[p][15:0], pats[p][31:16]} ^ (p == 0 ? 32'h8080_0080 : 32'h0080_8000));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule